// File: doc/BRIEF.md
# Modem Control Pin Controller

This block manages six active-low handshake pins that sit next to a serial port. Software reaches it through a byte-wide register port. It picks which pins are outputs and drives their output levels through separate set and clear registers. It can also read back the live level of every pin, and it flags changes on input pins with a sticky interrupt.

A mode field can give one pin, and one transmit gate, to automatic handshaking with the neighbouring UART. In that case the pin follows the receiver's readiness or the transmitter's activity instead of the software latch. The transmitter is then allowed to send only while the matching input pin is asserted.

Each pin has a fixed bit position in every pin-wide register:

| Bit | Pin |
|-----|-----|
| 0 | ring indicator |
| 1 | carrier detect |
| 2 | peer-ready input |
| 3 | local-ready output |
| 4 | transmit grant input |
| 5 | transmit request output |

A pin level of 0 means the signal is asserted.

Top module: `mdm_pin_ctrl`

## Requirements
- R1: After reset the pin levels behave as follows:
  - every output level is 1 (deasserted) and `irq` is 0.
  - `pad_oe` is 0x28, which makes bits 3 and 5 outputs and the other four pins inputs.
  - the mode register reads 0, and the interrupt mask reads 0x3F (all pins masked).
- R2: The register addresses are:

  | Address | Register |
  |---------|----------|
  | 0x1A | mode (3 bits) |
  | 0x1B | direction (1 = output) |
  | 0x1C | interrupt mask (1 = masked) |
  | 0x1D | set |
  | 0x1E | clear |
  | 0x1F | status |

  A read returns its data on `rdata` one clock edge after `rd_en`. Bits above a register's width read as 0.
- R3: Writing to the set and clear registers works as follows:
  - Writing to 0x1D sets each output latch bit whose data bit is 1.
  - Writing to 0x1E clears each output latch bit whose data bit is 1.
  - Zero data bits leave the latch unchanged.
  - The latch drives `pad_out` from the next edge.
  - Reads of 0x1D or 0x1E return the latch.
- R4: In manual mode, `pad_oe` equals the direction register.
- R5: Status bit i is computed from the pin's direction:
  - For a pin that is not an output, it is `pad_in[i]` passed through a two-flop synchronizer, so it is visible two edges after the pin changes.
  - For an output pin, it is the level being driven.
- R6: A change on a pin that is an input and not masked sets `irq` three edges after the change. Changes on masked pins or output pins never set it.
- R7: `irq` stays high until a status read. The read clears it at the read edge, unless a new change arrives in the same cycle.
- R8: Mode 1 (request/grant handshake) works as follows:
  - Bit 5 is forced to an output at level `~uart_rx_ready`.
  - `uart_tx_allow` is 1 only while synchronized bit 4 is 0.
  - Set and clear writes still update the latch but do not reach bit 5.
- R9: Mode 2 (ready handshake) works as follows:
  - Bit 3 is forced to an output at level `~uart_rx_ready`.
  - `uart_tx_allow` is 1 only while synchronized bit 2 is 0.
- R10: In modes 3 and 4 (half-duplex bus, plain and addressed), bit 5 is forced to an output at level `~uart_tx_busy`, and `uart_tx_allow` is 1.
- R11: In mode 0 and the unassigned modes 5 to 7, all pins follow the latch and direction register, and `uart_tx_allow` is 1.
- R12: A write to the status address or to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 8 | register address |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, registered |
| pad_in | input | 6 | pin levels from the pads |
| pad_out | output | 6 | pin levels to the pads |
| pad_oe | output | 6 | pad output enables |
| uart_rx_ready | input | 1 | receiver can accept data |
| uart_tx_busy | input | 1 | transmitter is shifting a frame |
| uart_tx_allow | output | 1 | transmitter may start a frame |
| irq | output | 1 | sticky pin-change interrupt |

## Verification
Each result is due a fixed number of edges after its stimulus:

| Result | Edges after stimulus |
|--------|----------------------|
| `pad_out` and `pad_oe` after a write | 1 |
| `rdata` after a read strobe | 1 |
| status and `uart_tx_allow` after a pad change | 2 |
| `irq` after a pad change | 3 |

Handshake inputs from the UART reach the pins combinationally. The bench changes inputs on falling edges and counts rising edges before it samples on a later falling edge. For the interrupt it checks both sides of the boundary: `irq` must still be low after two edges and high after three.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int PIN_W  = 6;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int MODE_W = 3;
    localparam int SYNC_STAGES = 2;

    // pin bit positions
    localparam int IDX_RING      = 0;
    localparam int IDX_CARRIER   = 1;
    localparam int IDX_PEER_RDY  = 2;
    localparam int IDX_LOCAL_RDY = 3;
    localparam int IDX_TX_GRANT  = 4;
    localparam int IDX_TX_REQ    = 5;

    // register addresses
    localparam logic [ADDR_W-1:0] A_MODE = 8'h1A;
    localparam logic [ADDR_W-1:0] A_DIR  = 8'h1B;
    localparam logic [ADDR_W-1:0] A_MASK = 8'h1C;
    localparam logic [ADDR_W-1:0] A_SET  = 8'h1D;
    localparam logic [ADDR_W-1:0] A_CLR  = 8'h1E;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h1F;

    // mode codes
    localparam logic [MODE_W-1:0] MD_MANUAL   = 3'd0;
    localparam logic [MODE_W-1:0] MD_REQ_GNT  = 3'd1;
    localparam logic [MODE_W-1:0] MD_READY    = 3'd2;
    localparam logic [MODE_W-1:0] MD_BUS      = 3'd3;
    localparam logic [MODE_W-1:0] MD_BUS_ADDR = 3'd4;

    localparam logic [PIN_W-1:0] DIR_RST  = (PIN_W'(1) << IDX_LOCAL_RDY) | (PIN_W'(1) << IDX_TX_REQ);
    localparam logic [PIN_W-1:0] MASK_RST = '1;
    localparam logic [PIN_W-1:0] OUT_RST  = '1;

    typedef struct packed {
        logic                  mode_hit;
        logic                  dir_hit;
        logic                  mask_hit;
        logic                  set_hit;
        logic                  clr_hit;
        logic [DATA_W-1:0]     data;
    } reg_wr_t;

    function automatic reg_wr_t decode_wr(input logic en,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [DATA_W-1:0] d);
        reg_wr_t r;
        r.mode_hit = en && (a == A_MODE);
        r.dir_hit  = en && (a == A_DIR);
        r.mask_hit = en && (a == A_MASK);
        r.set_hit  = en && (a == A_SET);
        r.clr_hit  = en && (a == A_CLR);
        r.data     = d;
        return r;
    endfunction

    // one-hot set of pins taken over by the handshake logic
    function automatic logic [PIN_W-1:0] auto_owned(input logic [MODE_W-1:0] m);
        logic [PIN_W-1:0] v;
        v = '0;
        case (m)
            MD_REQ_GNT, MD_BUS, MD_BUS_ADDR: v[IDX_TX_REQ]    = 1'b1;
            MD_READY:                        v[IDX_LOCAL_RDY] = 1'b1;
            default:                         v = '0;
        endcase
        return v;
    endfunction

    // pin level driven on the owned pin (active low)
    function automatic logic auto_level(input logic [MODE_W-1:0] m,
                                        input logic rx_ready,
                                        input logic tx_busy);
        logic lvl;
        case (m)
            MD_BUS, MD_BUS_ADDR: lvl = ~tx_busy;
            default:             lvl = ~rx_ready;
        endcase
        return lvl;
    endfunction

    // one-hot input pin that gates the transmitter, zero when ungated
    function automatic logic [PIN_W-1:0] gate_src(input logic [MODE_W-1:0] m);
        logic [PIN_W-1:0] v;
        v = '0;
        case (m)
            MD_REQ_GNT: v[IDX_TX_GRANT] = 1'b1;
            MD_READY:   v[IDX_PEER_RDY] = 1'b1;
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W = 6,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
    import mdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [MODE_W-1:0]   mode_q,
    output logic [PIN_W-1:0]    dir_q,
    output logic [PIN_W-1:0]    mask_q,
    output logic [PIN_W-1:0]    latch_q
);
    reg_wr_t wr;
    logic    unused_hi;

    assign wr        = decode_wr(wr_en, addr, wdata);
    assign unused_hi = ^wr.data[DATA_W-1:PIN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MD_MANUAL;
            dir_q   <= DIR_RST;
            mask_q  <= MASK_RST;
            latch_q <= OUT_RST;
        end else begin
            if (wr.mode_hit) mode_q <= wr.data[MODE_W-1:0];
            if (wr.dir_hit)  dir_q  <= wr.data[PIN_W-1:0];
            if (wr.mask_hit) mask_q <= wr.data[PIN_W-1:0];
            if (wr.set_hit)
                latch_q <= latch_q | wr.data[PIN_W-1:0];
            else if (wr.clr_hit)
                latch_q <= latch_q & ~wr.data[PIN_W-1:0];
        end
    end
endmodule

// File: rtl/mdm_pin_mux.sv
module mdm_pin_mux
    import mdm_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [PIN_W-1:0]  latch,
    input  logic [PIN_W-1:0]  dir,
    input  logic [PIN_W-1:0]  pins_sync,
    input  logic              rx_ready,
    input  logic              tx_busy,
    output logic [PIN_W-1:0]  out_lvl,
    output logic [PIN_W-1:0]  out_en,
    output logic              tx_allow
);
    logic [PIN_W-1:0] owned;
    logic [PIN_W-1:0] gate;
    logic             lvl;

    assign owned = auto_owned(mode);
    assign gate  = gate_src(mode);
    assign lvl   = auto_level(mode, rx_ready, tx_busy);

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        assign out_lvl[i] = owned[i] ? lvl  : latch[i];
        assign out_en[i]  = owned[i] ? 1'b1 : dir[i];
    end

    // gating pin is active low: allowed while it reads 0
    assign tx_allow = (gate == '0) ? 1'b1 : ((pins_sync & gate) == '0);
endmodule

// File: rtl/mdm_irq.sv
module mdm_irq
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] pins_sync,
    input  logic [PIN_W-1:0] out_en,
    input  logic [PIN_W-1:0] mask,
    input  logic             ack,
    output logic             irq
);
    logic [PIN_W-1:0] prev_q;
    logic [PIN_W-1:0] change;

    assign change = (pins_sync ^ prev_q) & ~out_en & ~mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= OUT_RST;
            irq    <= 1'b0;
        end else begin
            prev_q <= pins_sync;
            irq    <= (irq & ~ack) | (|change);
        end
    end
endmodule

// File: rtl/mdm_pin_ctrl.sv
module mdm_pin_ctrl
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    input  logic              uart_rx_ready,
    input  logic              uart_tx_busy,
    output logic              uart_tx_allow,
    output logic              irq
);
    logic [MODE_W-1:0] mode_q;
    logic [PIN_W-1:0]  dir_q, mask_q, latch_q, sync_q;
    logic [PIN_W-1:0]  out_w, oe_w, status_w;
    logic              stat_rd;

    mdm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mode_q(mode_q), .dir_q(dir_q), .mask_q(mask_q), .latch_q(latch_q)
    );

    mdm_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(OUT_RST)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
    );

    mdm_pin_mux u_mux (
        .mode(mode_q), .latch(latch_q), .dir(dir_q), .pins_sync(sync_q),
        .rx_ready(uart_rx_ready), .tx_busy(uart_tx_busy),
        .out_lvl(out_w), .out_en(oe_w), .tx_allow(uart_tx_allow)
    );

    assign stat_rd = rd_en && (addr == A_STAT);

    mdm_irq u_irq (
        .clk(clk), .rst(rst), .pins_sync(sync_q), .out_en(oe_w),
        .mask(mask_q), .ack(stat_rd), .irq(irq)
    );

    assign status_w = (sync_q & ~oe_w) | (out_w & oe_w);
    assign pad_out  = out_w;
    assign pad_oe   = oe_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                A_MODE:       rdata <= DATA_W'(mode_q);
                A_DIR:        rdata <= DATA_W'(dir_q);
                A_MASK:       rdata <= DATA_W'(mask_q);
                A_SET, A_CLR: rdata <= DATA_W'(latch_q);
                A_STAT:       rdata <= DATA_W'(status_w);
                default:      rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/mdm_pin_ctrl_chk.sv
module mdm_pin_ctrl_chk
    import mdm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [PIN_W-1:0]  pad_out,
    input logic [PIN_W-1:0]  pad_oe,
    input logic              uart_tx_allow,
    input logic              irq,
    input logic [MODE_W-1:0] mode
);
    p_set_high_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_SET && mode == MD_MANUAL)
        |=> ((pad_out & $past(wdata[PIN_W-1:0])) == $past(wdata[PIN_W-1:0])));

    p_clear_low_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CLR && mode == MD_MANUAL)
        |=> ((pad_out & $past(wdata[PIN_W-1:0])) == '0));

    p_zero_bits_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == A_SET || addr == A_CLR) && mode == MD_MANUAL)
        |=> (((pad_out ^ $past(pad_out)) & ~$past(wdata[PIN_W-1:0])) == '0));

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !(rd_en && addr == A_STAT)) |=> irq);

    p_manual_allow_r11: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_MANUAL) |-> uart_tx_allow);

    p_req_pin_driven_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_REQ_GNT) |-> pad_oe[IDX_TX_REQ]);
endmodule

bind mdm_pin_ctrl mdm_pin_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pad_out(pad_out), .pad_oe(pad_oe),
    .uart_tx_allow(uart_tx_allow), .irq(irq), .mode(mode_q)
);

// File: tb/mdm_pin_ctrl_tb.sv
`timescale 1ns/1ps
module mdm_pin_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic [5:0] pad_in = 6'h3F;
    logic [5:0] pad_out, pad_oe;
    logic       uart_rx_ready = 1'b0, uart_tx_busy = 1'b0;
    logic       uart_tx_allow, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [5:0] m_latch = 6'h3F;
    logic [5:0] m_dir = 6'h28;

    always #2 clk = ~clk;

    mdm_pin_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .uart_rx_ready(uart_rx_ready),
        .uart_tx_busy(uart_tx_busy), .uart_tx_allow(uart_tx_allow), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk("R1 pad_out", {2'b0, pad_out}, 8'h3F);
        chk("R1 pad_oe", {2'b0, pad_oe}, 8'h28);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd(8'h1A, d); chk("R1 mode", d, 8'h00);
        rd(8'h1C, d); chk("R1 mask", d, 8'h3F);
        rd(8'h1B, d); chk("R2 dir read", d, 8'h28);

        // R2 widths
        wr(8'h1A, 8'hFF); rd(8'h1A, d); chk("R2 mode width", d, 8'h07);
        wr(8'h1A, 8'h00);
        wr(8'h1C, 8'hC5); rd(8'h1C, d); chk("R2 mask width", d, 8'h05);
        wr(8'h1C, 8'h3F);

        // R3 set/clear sweep
        for (int v = 0; v < 64; v++) begin
            logic [5:0] c;
            c = 6'((v * 37) & 63);
            wr(8'h1D, 8'(v));
            m_latch = m_latch | 6'(v);
            chk("R3 set", {2'b0, pad_out}, {2'b0, m_latch});
            wr(8'h1E, {2'b11, c});
            m_latch = m_latch & ~c;
            chk("R3 clear", {2'b0, pad_out}, {2'b0, m_latch});
            if (v % 16 == 0) begin
                rd(8'h1E, d); chk("R3 latch read", d, {2'b0, m_latch});
            end
        end

        // R12 ignored writes
        wr(8'h1F, 8'h00);
        wr(8'h20, 8'h00);
        wr(8'h19, 8'hFF);
        rd(8'h1D, d); chk("R12 latch", d, {2'b0, m_latch});
        rd(8'h1B, d); chk("R12 dir", d, 8'h28);
        rd(8'h1A, d); chk("R12 mode", d, 8'h00);
        chk("R12 pad_out", {2'b0, pad_out}, {2'b0, m_latch});

        // R4 direction sweep
        for (int v = 0; v < 64; v += 3) begin
            wr(8'h1B, 8'(v));
            chk("R4 pad_oe", {2'b0, pad_oe}, 8'(v));
        end
        wr(8'h1B, 8'h28);

        // R5 status
        wr(8'h1E, 8'h3F); wr(8'h1D, 8'h20); m_latch = 6'h20;
        for (int p = 0; p < 64; p += 5) begin
            @(negedge clk); pad_in = 6'(p);
            tick(1);
            rd(8'h1F, d);
            chk("R5 status", d, {2'b0, (6'(p) & ~m_dir) | (m_latch & m_dir)});
        end
        @(negedge clk); pad_in = 6'h01;
        tick(1);
        rd(8'h1F, d); chk("R5 two-edge latency", d, 8'h20 | 8'h01);

        // R6 interrupt timing
        wr(8'h1C, 8'h00);
        tick(4);
        rd(8'h1F, d);
        chk("R6 idle irq", {7'b0, irq}, 8'h00);
        @(negedge clk); pad_in[2] = ~pad_in[2];
        tick(2); chk("R6 irq before", {7'b0, irq}, 8'h00);
        tick(1); chk("R6 irq after three", {7'b0, irq}, 8'h01);
        rd(8'h1F, d); chk("R7 cleared by read", {7'b0, irq}, 8'h00);
        @(negedge clk); pad_in[3] = ~pad_in[3];
        tick(5); chk("R6 output pin no irq", {7'b0, irq}, 8'h00);
        wr(8'h1C, 8'h01);
        @(negedge clk); pad_in[0] = ~pad_in[0];
        tick(5); chk("R6 masked no irq", {7'b0, irq}, 8'h00);
        @(negedge clk); pad_in[1] = ~pad_in[1];
        tick(4); chk("R7 set", {7'b0, irq}, 8'h01);
        tick(6); chk("R7 sticky", {7'b0, irq}, 8'h01);
        rd(8'h1A, d); chk("R7 other read keeps", {7'b0, irq}, 8'h01);
        rd(8'h1F, d); chk("R7 status read clears", {7'b0, irq}, 8'h00);
        wr(8'h1C, 8'h3F);

        // R8-R11 mode sweep
        wr(8'h1E, 8'h3F); m_latch = 6'h00;
        for (int m = 0; m < 8; m++) begin
            wr(8'h1A, 8'(m));
            for (int k = 0; k < 16; k++) begin
                logic [5:0] pin, eo, ee;
                logic ea, rx, bz;
                rx = k[2]; bz = k[3];
                pin = 6'h3F; pin[4] = k[0]; pin[2] = k[1];
                @(negedge clk);
                pad_in = pin; uart_rx_ready = rx; uart_tx_busy = bz;
                tick(2);
                eo = m_latch; ee = m_dir; ea = 1'b1;
                case (m)
                    1: begin eo[5] = ~rx; ee[5] = 1'b1; ea = ~pin[4]; end
                    2: begin eo[3] = ~rx; ee[3] = 1'b1; ea = ~pin[2]; end
                    3, 4: begin eo[5] = ~bz; ee[5] = 1'b1; end
                    default: ;
                endcase
                case (m)
                    1: begin
                        chk("R8 pad_out", {2'b0, pad_out}, {2'b0, eo});
                        chk("R8 allow", {7'b0, uart_tx_allow}, {7'b0, ea});
                    end
                    2: begin
                        chk("R9 pad_out", {2'b0, pad_out}, {2'b0, eo});
                        chk("R9 allow", {7'b0, uart_tx_allow}, {7'b0, ea});
                    end
                    3, 4: begin
                        chk("R10 pad_out", {2'b0, pad_out}, {2'b0, eo});
                        chk("R10 pad_oe", {2'b0, pad_oe}, {2'b0, ee});
                        chk("R10 allow", {7'b0, uart_tx_allow}, {7'b0, ea});
                    end
                    default: begin
                        chk("R11 pad_out", {2'b0, pad_out}, {2'b0, eo});
                        chk("R11 pad_oe", {2'b0, pad_oe}, {2'b0, ee});
                        chk("R11 allow", {7'b0, uart_tx_allow}, {7'b0, ea});
                    end
                endcase
            end
        end

        // R8 latch still written, pin untouched
        wr(8'h1A, 8'h01);
        @(negedge clk); uart_rx_ready = 1'b1;
        wr(8'h1D, 8'h20);
        rd(8'h1D, d); chk("R8 latch updated", d, 8'h20);
        chk("R8 pin not from latch", {7'b0, pad_out[5]}, 8'h00);
        chk("R8 oe forced", {7'b0, pad_oe[5]}, 8'h01);
        wr(8'h1A, 8'h00);
        chk("R11 latch back on pin", {7'b0, pad_out[5]}, 8'h01);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule